// File: doc/BRIEF.md
# Buffered Serial Mode-Control Register

This block holds an 8-bit mode word for a frequency synthesizer. The word is shifted in one bit per serial tick and is then moved into a holding buffer when the write strobe falls. Only the buffered copy drives anything, so the outputs keep their old meaning while a new word is still arriving. An active-low enable input sits in front of every function. While it is high, all function outputs are inactive, whatever the buffer holds. This covers the power-up period, when the buffer contents are unknown.

The buffered bits drive two control outputs. One powers the synthesizer down. The other requests continuous loading of the counter programming values. The buffered bits also choose what appears on one diagnostic pin. The choices are:
- a serialized copy of a separate parallel word, sent LSB first;
- the main-counter output;
- the prescaler modulus-select signal;
- the reference-counter output.

The counters and the prescaler sit outside the block and arrive as plain inputs. Programming more than one diagnostic source is a usage error. In that case a fixed priority decides which source is shown, and a sticky flag records the error.

Top module: `mode_ctl_reg`

## Requirements
- R1: The word enters MSB first. On each clock with `ser_en` high, the shift register moves up one place and takes `ser_din` into bit 0. After eight ticks, the first bit received is bit 7 and the last bit received is bit 0.
- R2: The buffer takes the shift register contents only on a clock where `wr_strobe` is sampled low after being sampled high on the previous clock. Shifting, a high strobe and a rising strobe all leave the outputs unchanged.
- R3: While `enh_n` is high, `pwr_down`, `cnt_load` and `diag_out` are 0, and `sel_conflict` does not become set.
- R4: While `enh_n` is low, `pwr_down` equals buffered bit 3 and `cnt_load` equals buffered bit 4.
- R5: Buffered bit 1 selects the serial readout on `diag_out`. The readout is loaded from `par_word` on the capture edge where bit 1 goes from 0 to 1; on that edge it shows `par_word` bit 0. Each later `ser_en` tick moves to the next higher bit. After all bits have gone out it shows 0. A capture that keeps bit 1 set does not reload the readout.
- R6: Buffered bit 2 shows `main_cnt_in`, bit 5 shows `mod_sel_in` and bit 6 shows `ref_cnt_in`. Each passes combinationally to `diag_out`.
- R7: When several of bits 1, 2, 5 and 6 are set, the source shown follows the priority bit 1 > bit 2 > bit 5 > bit 6. When none of these bits is set, `diag_out` is 0.
- R8: `sel_conflict` goes to 1 one clock after the buffer holds more than one diagnostic select bit while `enh_n` is low. It stays at 1 until reset.
- R9: Buffered bits 0 and 7 are reserved and affect no output.
- R10: While synchronous reset `rst` is high, it clears the shift register, the buffer, the strobe history, the readout and the conflict flag. All outputs are therefore 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the serial port is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ser_en | input | 1 | Serial tick: shift one bit in and advance the readout |
| ser_din | input | 1 | Serial data bit |
| wr_strobe | input | 1 | Write strobe; its falling edge loads the buffer |
| enh_n | input | 1 | Active-low enable for every function |
| par_word | input | PAR_W | Parallel word that is sent out serially |
| main_cnt_in | input | 1 | Main-counter output |
| mod_sel_in | input | 1 | Prescaler modulus-select signal |
| ref_cnt_in | input | 1 | Reference-counter output |
| pwr_down | output | 1 | Power-down request |
| cnt_load | output | 1 | Continuous counter-load request |
| diag_out | output | 1 | Diagnostic pin |
| sel_conflict | output | 1 | Sticky flag: more than one diagnostic source was selected |

## Verification
A fault in the shift order or in the capture edge shows up on the first write that follows it. The wrong function output turns on, or an output changes while bits are still arriving, and this is visible on the clock after the strobe falls. A fault in the readout shifter shows on `diag_out` at the capture edge or at the first serial tick after it; a readout that fails to drain shows eight ticks later. A conflict flag that does not set, or that clears itself, shows one or two clocks after a multi-select word is buffered.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

    // Buffered bit positions decoded by the function logic.
    localparam int BIT_SER_SEL  = 1;
    localparam int BIT_MAIN_SEL = 2;
    localparam int BIT_PDN      = 3;
    localparam int BIT_LOAD     = 4;
    localparam int BIT_MSEL_SEL = 5;
    localparam int BIT_REF_SEL  = 6;

    typedef struct packed {
        logic ser_sel;
        logic main_sel;
        logic pdn;
        logic load;
        logic msel_sel;
        logic ref_sel;
    } fn_bits_t;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_SERIAL,
        SRC_MAIN,
        SRC_MODSEL,
        SRC_REF
    } diag_src_e;

endpackage

// File: rtl/mcr_shift_in.sv
module mcr_shift_in
    import mcr_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     ser_en,
    input  logic     ser_din,
    input  logic     wr_strobe,
    output fn_bits_t fn_o,
    output logic     serial_arm_o
);

    typedef struct packed {
        logic [REG_W-1:0] shift;
        logic [REG_W-1:0] shadow;
        logic             wr;
    } st_t;

    st_t  st_d, st_q;
    logic capture;

    always_comb begin
        st_d    = st_q;
        capture = st_q.wr & ~wr_strobe;
        if (ser_en) begin
            st_d.shift = {st_q.shift[REG_W-2:0], ser_din};
        end
        if (capture) begin
            st_d.shadow = st_q.shift;
        end
        st_d.wr = wr_strobe;

        serial_arm_o = capture & st_q.shift[BIT_SER_SEL] & ~st_q.shadow[BIT_SER_SEL];

        fn_o.ser_sel  = st_q.shadow[BIT_SER_SEL];
        fn_o.main_sel = st_q.shadow[BIT_MAIN_SEL];
        fn_o.pdn      = st_q.shadow[BIT_PDN];
        fn_o.load     = st_q.shadow[BIT_LOAD];
        fn_o.msel_sel = st_q.shadow[BIT_MSEL_SEL];
        fn_o.ref_sel  = st_q.shadow[BIT_REF_SEL];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(st_q.wr && !wr_strobe) |=> $stable(fn_o)); // R2

    AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (rst)
        (st_q.wr && !wr_strobe) |=> (fn_o.pdn == $past(st_q.shift[BIT_PDN]))); // R1

endmodule

// File: rtl/mcr_readout.sv
module mcr_readout #(
    parameter int PAR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             adv,
    input  logic [PAR_W-1:0] par_word,
    output logic             bit_o
);

    typedef struct packed {
        logic [PAR_W-1:0] sh;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.sh = par_word;
        end else if (adv) begin
            st_d.sh = {1'b0, st_q.sh[PAR_W-1:1]};
        end
        bit_o = st_q.sh[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_READOUT_LSB: assert property (@(posedge clk) disable iff (rst)
        load |=> (bit_o == $past(par_word[0]))); // R5

    AST_READOUT_DRAINED: assert property (@(posedge clk) disable iff (rst)
        (st_q.sh == '0 && !load) |=> !bit_o); // R5

endmodule

// File: rtl/mcr_diag_mux.sv
module mcr_diag_mux
    import mcr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enabled,
    input  fn_bits_t fn,
    input  logic     serial_bit,
    input  logic     main_in,
    input  logic     msel_in,
    input  logic     ref_in,
    output logic     diag_o,
    output logic     conflict_o
);

    typedef struct packed {
        logic conflict;
    } st_t;

    st_t       st_d, st_q;
    diag_src_e src;
    logic [3:0] sel;

    always_comb begin
        sel = {fn.ref_sel, fn.msel_sel, fn.main_sel, fn.ser_sel};
        src = SRC_NONE;
        if (enabled) begin
            if (fn.ser_sel)       src = SRC_SERIAL;
            else if (fn.main_sel) src = SRC_MAIN;
            else if (fn.msel_sel) src = SRC_MODSEL;
            else if (fn.ref_sel)  src = SRC_REF;
        end

        case (src)
            SRC_SERIAL: diag_o = serial_bit;
            SRC_MAIN:   diag_o = main_in;
            SRC_MODSEL: diag_o = msel_in;
            SRC_REF:    diag_o = ref_in;
            default:    diag_o = 1'b0;
        endcase

        st_d = st_q;
        if (enabled && ($countones(sel) > 1)) begin
            st_d.conflict = 1'b1;
        end
        conflict_o = st_q.conflict;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CONFLICT_STICKY: assert property (@(posedge clk) disable iff (rst)
        conflict_o |=> conflict_o); // R8

    AST_CONFLICT_SET: assert property (@(posedge clk) disable iff (rst)
        (enabled && $countones(sel) > 1) |=> conflict_o); // R8

    AST_DIAG_QUIET: assert property (@(posedge clk) disable iff (rst)
        !enabled |-> !diag_o); // R3

endmodule

// File: rtl/mode_ctl_reg.sv
module mode_ctl_reg
    import mcr_pkg::*;
#(
    parameter int REG_W = 8,
    parameter int PAR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_en,
    input  logic             ser_din,
    input  logic             wr_strobe,
    input  logic             enh_n,
    input  logic [PAR_W-1:0] par_word,
    input  logic             main_cnt_in,
    input  logic             mod_sel_in,
    input  logic             ref_cnt_in,
    output logic             pwr_down,
    output logic             cnt_load,
    output logic             diag_out,
    output logic             sel_conflict
);

    fn_bits_t fn;
    logic     serial_arm;
    logic     serial_bit;
    logic     enabled;

    assign enabled  = ~enh_n;
    assign pwr_down = enabled & fn.pdn;
    assign cnt_load = enabled & fn.load;

    mcr_shift_in #(.REG_W(REG_W)) shift_in_i (
        .clk          (clk),
        .rst          (rst),
        .ser_en       (ser_en),
        .ser_din      (ser_din),
        .wr_strobe    (wr_strobe),
        .fn_o         (fn),
        .serial_arm_o (serial_arm)
    );

    mcr_readout #(.PAR_W(PAR_W)) readout_i (
        .clk      (clk),
        .rst      (rst),
        .load     (serial_arm),
        .adv      (ser_en),
        .par_word (par_word),
        .bit_o    (serial_bit)
    );

    mcr_diag_mux diag_mux_i (
        .clk        (clk),
        .rst        (rst),
        .enabled    (enabled),
        .fn         (fn),
        .serial_bit (serial_bit),
        .main_in    (main_cnt_in),
        .msel_in    (mod_sel_in),
        .ref_in     (ref_cnt_in),
        .diag_o     (diag_out),
        .conflict_o (sel_conflict)
    );

    AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (rst)
        enh_n |-> (!pwr_down && !cnt_load && !diag_out)); // R3

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!sel_conflict && !fn.pdn && !fn.load)); // R10

endmodule

// File: tb/mode_ctl_reg_tb.sv
module mode_ctl_reg_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;

    // Vector layout: [15:8] word, [7] enh_n, [6] main, [5] msel, [4] ref,
    // [3] exp pwr_down, [2] exp cnt_load, [1] exp diag_out, [0] exp conflict
    localparam logic [15:0] VECS [NVEC] = '{
        16'h0808, 16'h1004, 16'h0442, 16'h0430, 16'h2022, 16'h4012,
        16'h18F0, 16'h8170, 16'h6431, 16'h6011, 16'h2443
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_en = 1'b0, ser_din = 1'b0, wr_strobe = 1'b0, enh_n = 1'b1;
    logic [7:0] par_word = 8'h00;
    logic main_cnt_in = 1'b0, mod_sel_in = 1'b0, ref_cnt_in = 1'b0;
    logic pwr_down, cnt_load, diag_out, sel_conflict;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mode_ctl_reg dut_i (
        .clk(clk), .rst(rst), .ser_en(ser_en), .ser_din(ser_din),
        .wr_strobe(wr_strobe), .enh_n(enh_n), .par_word(par_word),
        .main_cnt_in(main_cnt_in), .mod_sel_in(mod_sel_in), .ref_cnt_in(ref_cnt_in),
        .pwr_down(pwr_down), .cnt_load(cnt_load), .diag_out(diag_out),
        .sel_conflict(sel_conflict)
    );

    function automatic string vec_tag(int v);
        case (v)
            0:       return "R1 R4";
            1:       return "R4";
            6:       return "R3";
            7:       return "R9";
            8, 9, 10: return "R7 R8";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic shift_word(logic [7:0] w);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            ser_en  = 1'b1;
            ser_din = w[i];
        end
        @(negedge clk) ser_en = 1'b0;
    endtask

    // Strobe high for one clock, then low; the buffer updates on the next edge.
    task automatic strobe();
        wr_strobe = 1'b1;
        @(negedge clk) wr_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_word(logic [7:0] w);
        shift_word(w);
        strobe();
    endtask

    task automatic tick();
        ser_en = 1'b1;
        @(negedge clk) ser_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                finish_run();
            end
        end
    end

    initial begin
        // R10: reset state with enable low and all live inputs high
        enh_n = 1'b0; main_cnt_in = 1'b1; mod_sel_in = 1'b1; ref_cnt_in = 1'b1;
        do_reset();
        check("R10 pwr_down", pwr_down, 1'b0);
        check("R10 cnt_load", cnt_load, 1'b0);
        check("R10 diag_out", diag_out, 1'b0);
        check("R10 sel_conflict", sel_conflict, 1'b0);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            enh_n       = VECS[v][7];
            main_cnt_in = VECS[v][6];
            mod_sel_in  = VECS[v][5];
            ref_cnt_in  = VECS[v][4];
            write_word(VECS[v][15:8]);
            @(negedge clk);
            check({vec_tag(v), " pwr_down"}, pwr_down, VECS[v][3]);
            check({vec_tag(v), " cnt_load"}, cnt_load, VECS[v][2]);
            check({vec_tag(v), " diag_out"}, diag_out, VECS[v][1]);
            check({vec_tag(v), " sel_conflict"}, sel_conflict, VECS[v][0]);
        end

        // R8: conflict stays set after a single-select word
        write_word(8'h04);
        @(negedge clk);
        check("R8 sticky", sel_conflict, 1'b1);

        // R10: reset clears the flag
        do_reset();
        check("R10 conflict cleared", sel_conflict, 1'b0);

        // R2: buffer holds while shifting and while the strobe is high
        enh_n = 1'b0;
        write_word(8'h08);
        check("R2 loaded", pwr_down, 1'b1);
        shift_word(8'h00);
        check("R2 hold during shift", pwr_down, 1'b1);
        wr_strobe = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R2 hold while strobe high", pwr_down, 1'b1);
        wr_strobe = 1'b0;
        @(negedge clk);
        check("R2 falling edge captures", pwr_down, 1'b0);

        // R3: no conflict while enable is high
        do_reset();
        enh_n = 1'b1;
        write_word(8'h26);
        @(negedge clk);
        @(negedge clk);
        check("R3 no conflict while disabled", sel_conflict, 1'b0);

        // R5: serial readout of the parallel word, LSB first, then zero
        do_reset();
        enh_n = 1'b0;
        par_word = 8'hA5;
        write_word(8'h02);
        check("R5 bit 0", diag_out, 1'b1);
        for (int k = 1; k < 8; k++) begin
            tick();
            check($sformatf("R5 bit %0d", k), diag_out, par_word[k]);
        end
        tick();
        check("R5 drained", diag_out, 1'b0);
        tick();
        check("R5 stays drained", diag_out, 1'b0);
        write_word(8'h02);
        check("R5 no reload while bit stays set", diag_out, 1'b0);
        write_word(8'h00);
        par_word = 8'hC3;
        write_word(8'h02);
        check("R5 reload bit 0", diag_out, 1'b1);
        tick();
        check("R5 reload bit 1", diag_out, 1'b1);
        tick();
        check("R5 reload bit 2", diag_out, 1'b0);

        // R7: serial readout wins over main counter
        do_reset();
        enh_n = 1'b0;
        main_cnt_in = 1'b0;
        par_word = 8'h01;
        write_word(8'h06);
        check("R7 serial over main", diag_out, 1'b1);

        // R7: no select bit gives zero even with live inputs high
        main_cnt_in = 1'b1; mod_sel_in = 1'b1; ref_cnt_in = 1'b1;
        write_word(8'h18);
        check("R7 none selected", diag_out, 1'b0);

        done = 1'b1;
        finish_run();
    end

endmodule